// File: doc/BRIEF.md
# 32-bit Base Integer Instruction Field Decoder

This block splits a 32-bit base integer instruction word into the pieces an execution stage needs. It slices out the destination and source register indices and the two function fields. It rebuilds the immediate for whichever encoding format the major opcode selects, and in every case widens it to a signed 32-bit value. It also reports the format class of the word and flags words whose major opcode is not one of the eleven known groups.

The decoding is purely combinational. A build-time switch places one register stage on all outputs so that the decoder can sit at a pipeline boundary. With that stage on, every output shows the decode of the word that was present at the previous rising clock edge, and reset clears the stage. With it off, the clock and reset inputs are unused and the outputs follow the word directly.

Top module: `rvdec_top`

## Requirements
- R1: rd_o is word bits [11:7], rs1_o is bits [19:15], rs2_o is bits [24:20], funct3_o is bits [14:12] and funct7_o is bits [31:25], whatever the format.
- R2: For format I, imm_o is word bits [31:20] sign-extended from bit 11; word 0x00500093 gives 5 and word 0xffe00093 gives 0xFFFFFFFE.
- R3: For format S, imm_o takes bits [31:25] as imm[11:5] and bits [11:7] as imm[4:0], sign-extended from bit 11.
- R4: For format B, imm_o takes imm[12] from bit 31, imm[11] from bit 7, imm[10:5] from bits [30:25] and imm[4:1] from bits [11:8]; imm[0] is 0 and the value is sign-extended from bit 12.
- R5: For format U, imm_o is word bits [31:12] in its upper 20 bits with the low 12 bits zero.
- R6: For format J, imm_o takes imm[20] from bit 31, imm[19:12] from bits [19:12], imm[11] from bit 20 and imm[10:1] from bits [30:21]; imm[0] is 0 and the value is sign-extended from bit 20.
- R7: fmt_o uses the code R=0, I=1, S=2, B=3, U=4, J=5. Opcode (bits [6:0]) 0x03, 0x0F, 0x13, 0x67 and 0x73 give I; 0x23 gives S; 0x33 gives R; 0x17 and 0x37 give U; 0x63 gives B; 0x6F gives J. For format R, imm_o is 0.
- R8: Any other opcode value sets illegal_o to 1, with fmt_o at 0 and imm_o at 0; every listed opcode gives illegal_o 0.
- R9: With REG_OUT set (the default), all outputs change one clock after the word is applied; while rst_n is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| instr_i | input | 32 | Instruction word to decode |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| funct3_o | output | 3 | Three-bit function field |
| funct7_o | output | 7 | Seven-bit function field |
| imm_o | output | 32 | Sign-extended immediate for the decoded format |
| fmt_o | output | 3 | Format class code |
| illegal_o | output | 1 | Unknown major opcode |

## Verification
The illegal-opcode check and immediate assembly act on the same word in the same cycle, and the risky case is an unknown opcode whose upper bits would form a non-zero immediate under some format. The bench provokes it with words such as 0xffffffff and with a sweep of all 128 opcode values carrying dense upper bits, and judges that the flag is raised while the immediate and format read zero. Words are applied back to back, one per clock, so that each result is checked against its own word and not its neighbour.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  localparam int ILEN   = 32;
  localparam int OP_W   = 7;
  localparam int RIDX_W = 5;
  localparam int F3_W   = 3;
  localparam int F7_W   = ILEN - 25;
  localparam int FMT_W  = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_R = 3'd0,
    FMT_I = 3'd1,
    FMT_S = 3'd2,
    FMT_B = 3'd3,
    FMT_U = 3'd4,
    FMT_J = 3'd5
  } fmt_e;

  localparam logic [OP_W-1:0] OPC_LOAD   = 7'h03;
  localparam logic [OP_W-1:0] OPC_FENCE  = 7'h0F;
  localparam logic [OP_W-1:0] OPC_ALUI   = 7'h13;
  localparam logic [OP_W-1:0] OPC_AUIPC  = 7'h17;
  localparam logic [OP_W-1:0] OPC_STORE  = 7'h23;
  localparam logic [OP_W-1:0] OPC_ALUR   = 7'h33;
  localparam logic [OP_W-1:0] OPC_LUI    = 7'h37;
  localparam logic [OP_W-1:0] OPC_BRANCH = 7'h63;
  localparam logic [OP_W-1:0] OPC_JALR   = 7'h67;
  localparam logic [OP_W-1:0] OPC_JAL    = 7'h6F;
  localparam logic [OP_W-1:0] OPC_SYS    = 7'h73;

  typedef struct packed {
    fmt_e fmt;
    logic known;
  } opclass_t;

  typedef struct packed {
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [F3_W-1:0]   f3;
    logic [F7_W-1:0]   f7;
    logic [ILEN-1:0]   imm;
    fmt_e              fmt;
    logic              illegal;
  } dec_t;

  function automatic opclass_t classify(input logic [OP_W-1:0] op);
    opclass_t c;
    c.known = 1'b1;
    case (op)
      OPC_LOAD, OPC_FENCE, OPC_ALUI, OPC_JALR, OPC_SYS: c.fmt = FMT_I;
      OPC_STORE:            c.fmt = FMT_S;
      OPC_ALUR:             c.fmt = FMT_R;
      OPC_AUIPC, OPC_LUI:   c.fmt = FMT_U;
      OPC_BRANCH:           c.fmt = FMT_B;
      OPC_JAL:              c.fmt = FMT_J;
      default: begin
        c.fmt   = FMT_R;
        c.known = 1'b0;
      end
    endcase
    return c;
  endfunction

  function automatic logic [ILEN-1:0] imm_of_i(input logic [ILEN-1:0] w);
    return {{20{w[31]}}, w[31:20]};
  endfunction

  function automatic logic [ILEN-1:0] imm_of_s(input logic [ILEN-1:0] w);
    return {{20{w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [ILEN-1:0] imm_of_b(input logic [ILEN-1:0] w);
    return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  function automatic logic [ILEN-1:0] imm_of_u(input logic [ILEN-1:0] w);
    return {w[31:12], 12'h000};
  endfunction

  function automatic logic [ILEN-1:0] imm_of_j(input logic [ILEN-1:0] w);
    return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

endpackage

// File: rtl/rvdec_opclass.sv
module rvdec_opclass
  import rvdec_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output fmt_e            fmt_o,
  output logic            illegal_o
);

  opclass_t cls;

  always_comb begin
    cls       = classify(opcode_i);
    fmt_o     = cls.fmt;
    illegal_o = ~cls.known;
  end

endmodule

// File: rtl/rvdec_immgen.sv
module rvdec_immgen
  import rvdec_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  input  fmt_e            fmt_i,
  input  logic            illegal_i,
  output logic [ILEN-1:0] imm_o
);

  always_comb begin
    if (illegal_i) begin
      imm_o = '0;
    end else begin
      case (fmt_i)
        FMT_I:   imm_o = imm_of_i(instr_i);
        FMT_S:   imm_o = imm_of_s(instr_i);
        FMT_B:   imm_o = imm_of_b(instr_i);
        FMT_U:   imm_o = imm_of_u(instr_i);
        FMT_J:   imm_o = imm_of_j(instr_i);
        default: imm_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/rvdec_top.sv
module rvdec_top
  import rvdec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ILEN-1:0]   instr_i,
  output logic [RIDX_W-1:0] rd_o,
  output logic [RIDX_W-1:0] rs1_o,
  output logic [RIDX_W-1:0] rs2_o,
  output logic [F3_W-1:0]   funct3_o,
  output logic [F7_W-1:0]   funct7_o,
  output logic [ILEN-1:0]   imm_o,
  output logic [FMT_W-1:0]  fmt_o,
  output logic              illegal_o
);

  fmt_e            cls_fmt;
  logic            cls_illegal;
  logic [ILEN-1:0] imm_raw;
  dec_t            dec_now;
  dec_t            dec_out;

  rvdec_opclass u_opclass (
    .opcode_i  (instr_i[OP_W-1:0]),
    .fmt_o     (cls_fmt),
    .illegal_o (cls_illegal)
  );

  rvdec_immgen u_immgen (
    .instr_i   (instr_i),
    .fmt_i     (cls_fmt),
    .illegal_i (cls_illegal),
    .imm_o     (imm_raw)
  );

  always_comb begin
    dec_now.rd      = instr_i[11:7];
    dec_now.rs1     = instr_i[19:15];
    dec_now.rs2     = instr_i[24:20];
    dec_now.f3      = instr_i[14:12];
    dec_now.f7      = instr_i[ILEN-1:25];
    dec_now.imm     = imm_raw;
    dec_now.fmt     = cls_fmt;
    dec_now.illegal = cls_illegal;
  end

  generate
    if (REG_OUT) begin : g_reg
      dec_t dec_q;
      logic armed_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dec_q   <= '0;
          armed_q <= 1'b0;
        end else begin
          dec_q   <= dec_now;
          armed_q <= 1'b1;
        end
      end

      assign dec_out = dec_q;

      // R9
      one_cycle_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (rd_o == $past(instr_i[11:7]) && funct3_o == $past(instr_i[14:12])));
    end else begin : g_comb
      assign dec_out = dec_now;
    end
  endgenerate

  assign rd_o      = dec_out.rd;
  assign rs1_o     = dec_out.rs1;
  assign rs2_o     = dec_out.rs2;
  assign funct3_o  = dec_out.f3;
  assign funct7_o  = dec_out.f7;
  assign imm_o     = dec_out.imm;
  assign fmt_o     = dec_out.fmt;
  assign illegal_o = dec_out.illegal;

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (imm_o == '0 && fmt_o == FMT_R));

  // R7
  fmt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_o <= FMT_J);

  // R7
  rfmt_no_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_o == FMT_R) |-> (imm_o == '0));

  // R5
  upper_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_o == FMT_U) |-> (imm_o[11:0] == 12'h000));

  // R4
  branch_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_o == FMT_B) |-> (imm_o[0] == 1'b0 && imm_o[31:12] == {20{imm_o[12]}}));

  // R6
  jump_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_o == FMT_J) |-> (imm_o[0] == 1'b0 && imm_o[31:20] == {12{imm_o[20]}}));

  // R2
  itype_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_o == FMT_I) |-> (imm_o[31:11] == {21{funct7_o[6]}}));

  // R3
  stype_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_o == FMT_S) |-> (imm_o[4:0] == rd_o && imm_o[11:5] == funct7_o));

endmodule

// File: tb/rvdec_top_tb.sv
module rvdec_top_tb;

  typedef struct packed {
    logic [31:0] word;
    logic [4:0]  rd, rs1, rs2;
    logic [2:0]  f3;
    logic [6:0]  f7;
    logic [31:0] imm;
    logic [2:0]  fmt;
    logic        ill;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'hFFFF_FFFF;
  logic [4:0]  rd_o, rs1_o, rs2_o;
  logic [2:0]  funct3_o;
  logic [6:0]  funct7_o;
  logic [31:0] imm_o;
  logic [2:0]  fmt_o;
  logic        illegal_o;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  rvdec_top u_dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr),
    .rd_o(rd_o), .rs1_o(rs1_o), .rs2_o(rs2_o),
    .funct3_o(funct3_o), .funct7_o(funct7_o),
    .imm_o(imm_o), .fmt_o(fmt_o), .illegal_o(illegal_o)
  );

  // format codes per R7
  function automatic logic [2:0] ref_fmt(input logic [6:0] op, output logic ill);
    ill = 1'b0;
    if (op == 7'h33) return 3'd0;
    if (op == 7'h23) return 3'd2;
    if (op == 7'h63) return 3'd3;
    if (op == 7'h17 || op == 7'h37) return 3'd4;
    if (op == 7'h6F) return 3'd5;
    if (op == 7'h03 || op == 7'h0F || op == 7'h13 || op == 7'h67 || op == 7'h73) return 3'd1;
    ill = 1'b1;
    return 3'd0;
  endfunction

  function automatic logic [31:0] ref_imm(input logic [31:0] w, input logic [2:0] f, input logic ill);
    logic signed [31:0] sw;
    logic [31:0] r;
    sw = $signed(w);
    r  = 32'd0;
    if (!ill) begin
      case (f)
        3'd1: r = 32'(sw >>> 20);
        3'd2: r = (32'(sw >>> 25) << 5) | 32'(w[11:7]);
        3'd3: r = (32'(sw >>> 31) << 12) + (32'(w[7]) << 11)
                + (32'(w[30:25]) << 5) + (32'(w[11:8]) << 1);
        3'd4: r = w & 32'hFFFF_F000;
        3'd5: r = (32'(sw >>> 31) << 20) + (32'(w[19:12]) << 12)
                + (32'(w[20]) << 11) + (32'(w[30:21]) << 1);
        default: r = 32'd0;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                     input logic [31:0] w);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s word=%h actual=%h expected=%h", tag, w, act, exp);
    end
  endtask

  // driver: one word per clock, expected item pushed to the scoreboard
  task automatic drive(input logic [31:0] w);
    exp_t e;
    logic ill;
    @(negedge clk);
    instr  = w;
    e.word = w;
    e.rd   = w[11:7];
    e.rs1  = w[19:15];
    e.rs2  = w[24:20];
    e.f3   = w[14:12];
    e.f7   = w[31:25];
    e.fmt  = ref_fmt(w[6:0], ill);
    e.ill  = ill;
    e.imm  = ref_imm(w, e.fmt, ill);
    sb_q.push_back(e);
  endtask

  task automatic drive_known(input logic [31:0] w, input logic [31:0] imm_lit);
    chk("R2-R6 literal", ref_imm(w, ref_fmt(w[6:0], ill_dummy), 1'b0), imm_lit, w);
    drive(w);
  endtask
  logic ill_dummy;

  // monitor: registered output settles after the edge following the drive
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        exp_t e;
        string it;
        e = sb_q.pop_front();
        case (e.fmt)
          3'd1: it = "R2 imm I";
          3'd2: it = "R3 imm S";
          3'd3: it = "R4 imm B";
          3'd4: it = "R5 imm U";
          3'd5: it = "R6 imm J";
          default: it = e.ill ? "R8 imm zero" : "R7 imm R";
        endcase
        chk("R1 rd",     32'(rd_o),     32'(e.rd),  e.word);
        chk("R1 rs1",    32'(rs1_o),    32'(e.rs1), e.word);
        chk("R1 rs2",    32'(rs2_o),    32'(e.rs2), e.word);
        chk("R1 funct3", 32'(funct3_o), 32'(e.f3),  e.word);
        chk("R1 funct7", 32'(funct7_o), 32'(e.f7),  e.word);
        chk(it,          imm_o,         e.imm,      e.word);
        chk("R7 fmt",    32'(fmt_o),    32'(e.fmt), e.word);
        chk("R8 illegal", 32'(illegal_o), 32'(e.ill), e.word);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset holds every output at zero even with an all-ones word applied
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset rd",  32'(rd_o),      0, instr);
    chk("R9 reset imm", imm_o,          0, instr);
    chk("R9 reset fmt", 32'(fmt_o),     0, instr);
    chk("R9 reset ill", 32'(illegal_o), 0, instr);
    rst_n = 1'b1;

    // R2 given words, R3..R6 and R7 per format
    drive_known(32'h0050_0093, 32'd5);
    drive_known(32'hFFE0_0093, 32'hFFFF_FFFE);
    drive_known(32'hFE51_2E23, 32'hFFFF_FFFC);
    drive_known(32'h0020_8C63, 32'd24);
    drive_known(32'hFE20_8EE3, 32'hFFFF_FFFC);
    drive_known(32'h0007_B0B7, 32'd503808);
    drive_known(32'h0007_B097, 32'd503808);
    drive_known(32'h12C0_00EF, 32'd300);
    drive_known(32'hED5F_F0EF, 32'hFFFF_FED4);
    drive_known(32'hFF60_8167, 32'hFFFF_FFF6);
    drive(32'h4020_81B3);
    drive(32'h0000_000F);
    drive(32'h0000_0073);
    drive(32'hFFF0_2003);
    drive(32'h8000_0063);
    drive(32'h8000_006F);
    // R8: unknown opcodes with dense upper bits
    drive(32'hFFFF_FFFF);
    drive(32'hFFF0_000B);
    for (int op = 0; op < 128; op++) drive({25'h1A5_5A5A, 7'(op)});
    for (int k = 0; k < 64; k++) drive(32'h9E37_79B9 * 32'(k + 1));

    // R9: output stays with the last word one clock after input stops changing
    @(negedge clk);
    instr = 32'h0050_0093;
    @(posedge clk);
    #1;
    while (sb_q.size() > 0) @(negedge clk);
    @(posedge clk);
    #1;
    chk("R9 hold imm", imm_o, 32'd5, instr);
    chk("R9 hold rd",  32'(rd_o), 32'd1, instr);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule